// File: doc/BRIEF.md
# Address-Space Tagged Translation Buffer

This block is a small, fully associative cache of page translations. Each slot holds a virtual page number tag and a physical page number. It also holds an address-space identifier, a global flag that makes the slot match in every address space, per-privilege read and write permission masks, and two trap-on-access flags, one for reads and one for writes. A lookup port translates one virtual address per cycle with no register on the path. It returns the hit indication and the stored attributes of the matching slot.

A single command port accepts one operation per clock. The operations are: load a new translation, wipe every slot, wipe only the slots of private address spaces, and wipe one page. A load always goes to the slot named by a rotating replacement pointer. The address split, the tag width, the number of slots and the number of privilege modes are all parameters.

Top module: `asn_xlate_buf`

## Requirements
- R1: After reset no slot is valid, every lookup misses, and the replacement pointer names slot 0.
- R2: A lookup hits only when a valid slot holds a tag equal to the requested page number and that slot either has its global flag set or holds an address-space identifier equal to the requested one.
- R3: The page number is the virtual address above the low PG_OFF bits (default 13). The offset bits never affect a lookup or a page wipe.
- R4: A load (cmd_op = 1) writes the slot named by the replacement pointer and marks it valid, replacing any earlier contents. The pointer then steps by one, wrapping from ENTRIES-1 to 0.
- R5: On a hit, lk_ppn, lk_rd_en, lk_wr_en, lk_rd_trap and lk_wr_trap carry the fields of the matching slot. On a miss they are all zero.
- R6: When several valid slots match, the lowest-numbered slot supplies the outputs.
- R7: Wipe-all (cmd_op = 2) invalidates every slot and returns the replacement pointer to slot 0.
- R8: Wipe-private (cmd_op = 3) invalidates every slot whose global flag is clear and keeps the global slots.
- R9: Wipe-page (cmd_op = 4) invalidates every valid slot whose tag equals the page of cmd_va and that is either global or holds cmd_asn. All other slots keep their state.
- R10: A command takes effect at the clock edge that accepts it. A lookup in the same cycle sees the old contents, and a lookup in the following cycle sees the new contents. Codes 0, 5, 6 and 7 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 3 | Command: 0 idle, 1 load, 2 wipe all, 3 wipe private, 4 wipe page |
| cmd_va | input | VA_W | Virtual address for load and wipe-page |
| cmd_asn | input | ASN_W | Address-space identifier for load and wipe-page |
| cmd_ppn | input | PPN_W | Physical page for load |
| cmd_global | input | 1 | Global flag for load |
| cmd_rd_en | input | MODES | Read permission per privilege mode for load |
| cmd_wr_en | input | MODES | Write permission per privilege mode for load |
| cmd_rd_trap | input | 1 | Trap-on-read flag for load |
| cmd_wr_trap | input | 1 | Trap-on-write flag for load |
| lk_va | input | VA_W | Virtual address to translate |
| lk_asn | input | ASN_W | Current address-space identifier |
| lk_hit | output | 1 | Translation found |
| lk_ppn | output | PPN_W | Physical page of the hit |
| lk_rd_en | output | MODES | Read permission mask of the hit |
| lk_wr_en | output | MODES | Write permission mask of the hit |
| lk_rd_trap | output | 1 | Trap-on-read flag of the hit |
| lk_wr_trap | output | 1 | Trap-on-write flag of the hit |

## Verification
A lookup and a command can fall in the same cycle, and the most telling pair is a lookup together with a wipe. The bench holds a lookup on a global page steady while it issues wipe-all. It reads the outputs once before the accepting edge, where a hit from the old contents is expected, and once after it, where a miss is expected. Between commands, every page number of a small configuration is swept against every address-space identifier. Each result is compared with a model that is updated from the command rules.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
   typedef enum logic [2:0] {
      OP_IDLE      = 3'd0,
      OP_LOAD      = 3'd1,
      OP_WIPE      = 3'd2,
      OP_WIPE_PRIV = 3'd3,
      OP_WIPE_PAGE = 3'd4
   } op_e;
endpackage

// File: rtl/tlbx_rr.sv
module tlbx_rr #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             zero,
   output logic [IDX_W-1:0] ptr
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

   always_ff @(posedge clk) begin
      if (!rst_n || zero) ptr <= '0;
      else if (adv)       ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
   end

   AST_RR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= LAST); // R4
   AST_RR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !zero && ptr == LAST) |=> ptr == '0); // R4
   AST_RR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      zero |=> ptr == '0); // R7
endmodule

// File: rtl/tlbx_first.sv
module tlbx_first #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end
   assign any = |req;

   logic [N-1:0] below;
   assign below = (N'(1) << idx) - N'(1);

   AST_FIRST_PICK: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> (req[idx] && ((req & below) == '0))); // R6
endmodule

// File: rtl/tlbx_slot.sv
module tlbx_slot #(
   parameter int VPN_W = 19,
   parameter int PPN_W = 28,
   parameter int ASN_W = 8,
   parameter int MODES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             wipe_all,
   input  logic             wipe_priv,
   input  logic             wipe_page,
   input  logic [VPN_W-1:0] cmd_vpn,
   input  logic [ASN_W-1:0] cmd_asn,
   input  logic [PPN_W-1:0] new_ppn,
   input  logic             new_glob,
   input  logic [MODES-1:0] new_rd,
   input  logic [MODES-1:0] new_wr,
   input  logic             new_rtrap,
   input  logic             new_wtrap,
   input  logic [VPN_W-1:0] lk_vpn,
   input  logic [ASN_W-1:0] lk_asn,
   output logic             match,
   output logic             valid,
   output logic [PPN_W-1:0] ppn,
   output logic [MODES-1:0] rd,
   output logic [MODES-1:0] wr,
   output logic             rtrap,
   output logic             wtrap
);
   logic [VPN_W-1:0] tag;
   logic [ASN_W-1:0] asn;
   logic             glob;
   logic             page_hit;

   assign match    = valid && (tag == lk_vpn)  && (glob || asn == lk_asn);
   assign page_hit = valid && (tag == cmd_vpn) && (glob || asn == cmd_asn);

   always_ff @(posedge clk) begin
      if (!rst_n || wipe_all)            valid <= 1'b0;
      else if (load)                     valid <= 1'b1;
      else if (wipe_priv && !glob)       valid <= 1'b0;
      else if (wipe_page && page_hit)    valid <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || wipe_all) begin
         tag <= '0; asn <= '0; glob <= 1'b0; ppn <= '0;
         rd <= '0; wr <= '0; rtrap <= 1'b0; wtrap <= 1'b0;
      end else if (load) begin
         tag <= cmd_vpn; asn <= cmd_asn; glob <= new_glob; ppn <= new_ppn;
         rd <= new_rd; wr <= new_wr; rtrap <= new_rtrap; wtrap <= new_wtrap;
      end
   end

   AST_SLOT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !wipe_all) |=> valid); // R4
   AST_SLOT_KEEP_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
      (wipe_priv && !load && !wipe_all && valid && glob) |=> valid); // R8
   AST_SLOT_PAGE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (wipe_page && !load && page_hit) |=> !valid); // R9
endmodule

// File: rtl/asn_xlate_buf.sv
module asn_xlate_buf #(
   parameter int ENTRIES = 8,
   parameter int VA_W    = 32,
   parameter int PG_OFF  = 13,
   parameter int PPN_W   = 28,
   parameter int ASN_W   = 8,
   parameter int MODES   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cmd_op,
   input  logic [VA_W-1:0]   cmd_va,
   input  logic [ASN_W-1:0]  cmd_asn,
   input  logic [PPN_W-1:0]  cmd_ppn,
   input  logic              cmd_global,
   input  logic [MODES-1:0]  cmd_rd_en,
   input  logic [MODES-1:0]  cmd_wr_en,
   input  logic              cmd_rd_trap,
   input  logic              cmd_wr_trap,
   input  logic [VA_W-1:0]   lk_va,
   input  logic [ASN_W-1:0]  lk_asn,
   output logic              lk_hit,
   output logic [PPN_W-1:0]  lk_ppn,
   output logic [MODES-1:0]  lk_rd_en,
   output logic [MODES-1:0]  lk_wr_en,
   output logic              lk_rd_trap,
   output logic              lk_wr_trap
);
   import tlbx_pkg::*;

   localparam int VPN_W = VA_W - PG_OFF;
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   initial begin
      assert (ENTRIES >= 2) else $error("ENTRIES must be at least 2");
      assert (PG_OFF >= 1 && PG_OFF < VA_W) else $error("PG_OFF out of range");
      assert (MODES >= 1) else $error("MODES must be at least 1");
   end

   op_e op;
   assign op = op_e'(cmd_op);

   logic do_load, do_wipe, do_priv, do_page;
   assign do_load = (op == OP_LOAD);
   assign do_wipe = (op == OP_WIPE);
   assign do_priv = (op == OP_WIPE_PRIV);
   assign do_page = (op == OP_WIPE_PAGE);

   logic [VPN_W-1:0] cmd_vpn, lk_vpn;
   assign cmd_vpn = cmd_va[VA_W-1:PG_OFF];
   assign lk_vpn  = lk_va[VA_W-1:PG_OFF];

   logic [IDX_W-1:0] ptr;
   tlbx_rr #(.N(ENTRIES), .IDX_W(IDX_W)) u_rr (
      .clk(clk), .rst_n(rst_n), .adv(do_load), .zero(do_wipe), .ptr(ptr));

   logic [ENTRIES-1:0] match_v, valid_v;
   logic [PPN_W-1:0]   ppn_a   [ENTRIES];
   logic [MODES-1:0]   rd_a    [ENTRIES];
   logic [MODES-1:0]   wr_a    [ENTRIES];
   logic [ENTRIES-1:0] rtrap_v, wtrap_v;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      tlbx_slot #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ASN_W(ASN_W), .MODES(MODES)) u_slot (
         .clk(clk), .rst_n(rst_n),
         .load(do_load && ptr == IDX_W'(g)),
         .wipe_all(do_wipe), .wipe_priv(do_priv), .wipe_page(do_page),
         .cmd_vpn(cmd_vpn), .cmd_asn(cmd_asn),
         .new_ppn(cmd_ppn), .new_glob(cmd_global),
         .new_rd(cmd_rd_en), .new_wr(cmd_wr_en),
         .new_rtrap(cmd_rd_trap), .new_wtrap(cmd_wr_trap),
         .lk_vpn(lk_vpn), .lk_asn(lk_asn),
         .match(match_v[g]), .valid(valid_v[g]),
         .ppn(ppn_a[g]), .rd(rd_a[g]), .wr(wr_a[g]),
         .rtrap(rtrap_v[g]), .wtrap(wtrap_v[g]));
   end

   logic             any;
   logic [IDX_W-1:0] sel;
   tlbx_first #(.N(ENTRIES), .IDX_W(IDX_W)) u_first (
      .clk(clk), .rst_n(rst_n), .req(match_v), .any(any), .idx(sel));

   always_comb begin
      lk_hit     = any;
      lk_ppn     = '0;
      lk_rd_en   = '0;
      lk_wr_en   = '0;
      lk_rd_trap = 1'b0;
      lk_wr_trap = 1'b0;
      if (any) begin
         lk_ppn     = ppn_a[sel];
         lk_rd_en   = rd_a[sel];
         lk_wr_en   = wr_a[sel];
         lk_rd_trap = rtrap_v[sel];
         lk_wr_trap = wtrap_v[sel];
      end
   end

   AST_WIPE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      do_wipe |=> (valid_v == '0)); // R7
   AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (valid_v != '0)); // R2
   AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_ppn == '0 && lk_rd_en == '0 && lk_wr_en == '0
                   && !lk_rd_trap && !lk_wr_trap)); // R5
   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (op != OP_LOAD && op != OP_WIPE && op != OP_WIPE_PRIV && op != OP_WIPE_PAGE)
      |=> $stable(valid_v)); // R10
endmodule

// File: tb/sim_asn_xlate_buf.sv
`timescale 1ns/1ps
module sim_asn_xlate_buf;
   localparam int N = 4, VA_W = 20, PG_OFF = 13, PPN_W = 8, ASN_W = 2, MODES = 4;
   localparam int VPN_W = VA_W - PG_OFF;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [2:0] cmd_op = 3'd0;
   logic [VA_W-1:0] cmd_va = '0, lk_va = '0;
   logic [ASN_W-1:0] cmd_asn = '0, lk_asn = '0;
   logic [PPN_W-1:0] cmd_ppn = '0;
   logic cmd_global = 1'b0, cmd_rd_trap = 1'b0, cmd_wr_trap = 1'b0;
   logic [MODES-1:0] cmd_rd_en = '0, cmd_wr_en = '0;
   logic lk_hit, lk_rd_trap, lk_wr_trap;
   logic [PPN_W-1:0] lk_ppn;
   logic [MODES-1:0] lk_rd_en, lk_wr_en;

   always #4 clk = ~clk;

   asn_xlate_buf #(.ENTRIES(N), .VA_W(VA_W), .PG_OFF(PG_OFF), .PPN_W(PPN_W),
                   .ASN_W(ASN_W), .MODES(MODES)) u0 (.*);

   int total = 0, bad = 0;
   bit done = 0;

   bit               mv   [N];
   logic [VPN_W-1:0] mtag [N];
   logic [ASN_W-1:0] masn [N];
   bit               mglb [N];
   logic [PPN_W-1:0] mppn [N];
   logic [MODES-1:0] mrd  [N], mwr [N];
   bit               mrt  [N], mwt [N];
   int               mptr = 0;

   localparam int RW = 1 + PPN_W + 2*MODES + 2;

   task automatic chk(string rq, logic [RW-1:0] act, logic [RW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s va=%h asn=%0d actual=%h expected=%h", rq, lk_va, lk_asn, act, exp);
      end
   endtask

   function automatic logic [RW-1:0] model(logic [VPN_W-1:0] v, logic [ASN_W-1:0] a);
      for (int i = 0; i < N; i++)
         if (mv[i] && mtag[i] == v && (mglb[i] || masn[i] == a))
            return {1'b1, mppn[i], mrd[i], mwr[i], mrt[i], mwt[i]};
      return '0;
   endfunction

   function automatic logic [RW-1:0] outs();
      return {lk_hit, lk_ppn, lk_rd_en, lk_wr_en, lk_rd_trap, lk_wr_trap};
   endfunction

   // model update per R4, R7, R8, R9
   task automatic apply(int op, logic [VPN_W-1:0] v, logic [ASN_W-1:0] a, logic [PPN_W-1:0] p,
                        bit g, logic [MODES-1:0] r, logic [MODES-1:0] w, bit rt, bit wt);
      case (op)
         1: begin
            mv[mptr] = 1; mtag[mptr] = v; masn[mptr] = a; mglb[mptr] = g; mppn[mptr] = p;
            mrd[mptr] = r; mwr[mptr] = w; mrt[mptr] = rt; mwt[mptr] = wt;
            mptr = (mptr + 1) % N;
         end
         2: begin for (int i = 0; i < N; i++) mv[i] = 0; mptr = 0; end
         3: for (int i = 0; i < N; i++) if (!mglb[i]) mv[i] = 0;
         4: for (int i = 0; i < N; i++)
               if (mv[i] && mtag[i] == v && (mglb[i] || masn[i] == a)) mv[i] = 0;
         default: ;
      endcase
   endtask

   task automatic issue(int op, logic [VPN_W-1:0] v, logic [ASN_W-1:0] a, logic [PPN_W-1:0] p,
                        bit g, logic [MODES-1:0] r, logic [MODES-1:0] w, bit rt, bit wt);
      @(negedge clk);
      cmd_op = 3'(op); cmd_va = {v, PG_OFF'(v * 53 + 7)}; cmd_asn = a; cmd_ppn = p;
      cmd_global = g; cmd_rd_en = r; cmd_wr_en = w; cmd_rd_trap = rt; cmd_wr_trap = wt;
      @(posedge clk);
      apply(op, v, a, p, g, r, w, rt, wt);
      @(negedge clk);
      cmd_op = 3'd0;
   endtask

   // sweep every page and ASN; offset varies to cover R3, fields cover R5
   task automatic sweep(string rq);
      for (int v = 0; v < (1 << VPN_W); v++)
         for (int a = 0; a < (1 << ASN_W); a++) begin
            lk_va = {VPN_W'(v), PG_OFF'(v * 311 + a * 1999)};
            lk_asn = ASN_W'(a);
            #1;
            chk(rq, outs(), model(VPN_W'(v), ASN_W'(a)));
         end
   endtask

   initial begin
      for (int i = 0; i < N; i++) mv[i] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      sweep("R1");
      issue(1, 5, 1, 8'h11, 0, 4'b0011, 4'b0001, 0, 1);
      issue(1, 9, 0, 8'h22, 1, 4'b1111, 4'b0000, 1, 0);
      issue(1, 5, 2, 8'h33, 0, 4'b0101, 4'b1010, 0, 0);
      issue(1, 5, 3, 8'h44, 1, 4'b1000, 4'b0100, 1, 1);
      sweep("R2 R3 R5 R6");
      issue(1, 20, 3, 8'h55, 0, 4'b0110, 4'b0110, 0, 0);
      sweep("R4");
      issue(6, 5, 1, 0, 0, 0, 0, 0, 0);
      sweep("R10 idle code");
      issue(4, 5, 2, 0, 0, 0, 0, 0, 0);
      sweep("R9");
      issue(1, 9, 0, 8'h66, 0, 4'b0001, 4'b0001, 0, 0);
      issue(1, 30, 2, 8'h77, 1, 4'b0010, 4'b0010, 1, 0);
      issue(3, 0, 0, 0, 0, 0, 0, 0, 0);
      sweep("R8");
      // R10: lookup in same cycle as wipe-all sees old contents
      @(negedge clk);
      lk_va = {VPN_W'(30), PG_OFF'(123)}; lk_asn = 0;
      cmd_op = 3'd2;
      #1 chk("R10 before edge", outs(), model(30, 0));
      @(posedge clk);
      apply(2, 0, 0, 0, 0, 0, 0, 0, 0);
      #1 chk("R10 after edge", outs(), '0);
      @(negedge clk) cmd_op = 3'd0;
      sweep("R7 empty");
      issue(1, 40, 1, 8'h88, 1, 4'b0001, 4'b0000, 0, 0);
      issue(1, 40, 2, 8'h99, 1, 4'b0010, 4'b0000, 0, 0);
      sweep("R7 pointer");
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule